// File: doc/BRIEF.md
# Set-Associative Tag Store with Line Reservation

This block holds the tags and line states of a set-associative cache. A line can be held in a reserved state while its miss is still outstanding. A block address is presented on the lookup port. In the same cycle, combinationally, the block reports one of four outcomes and a line index. The outcomes are:

- a hit on a valid or dirty line;
- a pending hit on a reserved line;
- a miss together with the chosen victim;
- a failure when every way of the set is reserved.

When the lookup is qualified as an access, the state change it implies commits on the next clock edge. A miss reserves the victim under the new tag. A hit or pending hit refreshes the line's access time.

A separate fill port moves a line, addressed by its index, to the valid or dirty state once its data has arrived. A flush input invalidates the whole store. Four counters tally accesses, misses, pending hits and failures.

Timestamps come from an internal free-running cycle counter. The victim is chosen by the smallest timestamp. A build parameter selects what that timestamp is: the last-access time (least recently used) or the allocation time (first in, first out). When the chosen victim is dirty, a writeback indication is raised together with the evicted line's block-aligned byte address.

Top module: `tag_array_rsv`

## Requirements
- R1: After reset every line is invalid and all four counters read zero. Any lookup then reports a miss, no writeback, and line index set*WAYS (way 0).
- R2: The set is the low log2(SETS) bits of the block address `acc_blk_i`. The tag is the remaining upper bits. The line index is {set, way}, so it equals set*WAYS+way.
- R3: `res_o` encodes 0 = hit (tag match on a valid or dirty line), 1 = pending hit (tag match on a reserved line), 2 = miss, 3 = failure. A tag match on an invalid line does not count as a match.
- R4: With no hit and every way of the set reserved, the result is 3. `line_idx_o` then points at way 0 of the set, and no line changes.
- R5: On a miss the victim is the lowest-numbered invalid way. If no way is invalid, the victim is the valid or dirty way with the smallest timestamp, with ties going to the lowest way. An access that misses makes the victim reserved under the new tag, with its access time and allocation time both set to the current cycle count.
- R6: With `USE_FIFO`=0 the timestamp is the last-access time. A hit or pending hit access updates it to the current cycle count. With `USE_FIFO`=1 the timestamp is the allocation time, which hits leave untouched.
- R7: `wb_o` is 1 exactly when the result is a miss and the victim line is dirty. `wb_addr_o` is then {victim tag, set, zero offset}.
- R8: A fill sets line `fill_idx_i` to dirty when `fill_dirty_i` is 1 and to valid otherwise. It leaves tag and timestamps unchanged.
- R9: A flush makes every line invalid on the next edge. It overrides any fill or allocation in the same cycle, but that cycle's access is still counted.
- R10: Each access increments the access counter. It also increments the miss, pending-hit or failure counter, according to its result. The counters wrap at 2^CNT_W.
- R11: A fill and an access in the same cycle are both applied. The lookup result reflects the state before that edge. If the fill and the allocation target the same line, the allocation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Commit the current lookup as an access |
| acc_blk_i | input | ADDR_W-log2(LINE_BYTES) | Block address to look up |
| res_o | output | 2 | Lookup outcome code |
| line_idx_o | output | log2(SETS*WAYS) | Hit line or victim line index |
| wb_o | output | 1 | Victim of this miss is dirty |
| wb_addr_o | output | ADDR_W | Byte address of the dirty victim |
| fill_valid_i | input | 1 | Fill request |
| fill_idx_i | input | log2(SETS*WAYS) | Line index to fill |
| fill_dirty_i | input | 1 | Fill leaves the line dirty |
| flush_i | input | 1 | Invalidate all lines |
| cnt_access_o | output | CNT_W | Access count |
| cnt_miss_o | output | CNT_W | Miss count |
| cnt_pend_o | output | CNT_W | Pending-hit count |
| cnt_fail_o | output | CNT_W | Failure count |

## Verification
Two pairs of operations can share a cycle: a fill with an access, and a flush with an access. The directed part fills the line that the current access pending-hits, in the same cycle. It expects the pending-hit outcome first and a plain hit afterwards. It also issues a flush alongside an allocating access and expects every following lookup to miss while the counters still advance. The random part fires fills, flushes and accesses independently, so all of these coincide many times, including fills aimed at the very line being allocated. Every cycle is compared against the bench's own state model for both victim policies.

// File: rtl/tag_arr_pkg.sv
package tag_arr_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_RSV = 2'd1,
    LS_VAL = 2'd2,
    LS_MOD = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    RES_HIT  = 2'd0,
    RES_PEND = 2'd1,
    RES_MISS = 2'd2,
    RES_FAIL = 2'd3
  } look_res_e;
endpackage

// File: rtl/tag_arr_lookup.sv
module tag_arr_lookup
  import tag_arr_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  parameter int TS_W  = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][1:0]       st_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0][TS_W-1:0]  ts_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic [1:0]                 res_o,
  output logic [WAY_W-1:0]           way_o
);
  logic             hit_f, pend_f, free_f, inv_f, val_f;
  logic [WAY_W-1:0] hit_w, inv_w, val_w;
  logic [TS_W-1:0]  best_ts;

  always_comb begin
    hit_f   = 1'b0;
    pend_f  = 1'b0;
    free_f  = 1'b0;
    inv_f   = 1'b0;
    val_f   = 1'b0;
    hit_w   = '0;
    inv_w   = '0;
    val_w   = '0;
    best_ts = '1;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit_f && st_i[w] != LS_INV && tag_i[w] == key_i) begin
        hit_f  = 1'b1;
        hit_w  = WAY_W'(w);
        pend_f = (st_i[w] == LS_RSV);
      end
      if (st_i[w] != LS_RSV) begin
        free_f = 1'b1;
        if (st_i[w] == LS_INV) begin
          if (!inv_f) begin
            inv_f = 1'b1;
            inv_w = WAY_W'(w);
          end
        end else if (!val_f || ts_i[w] < best_ts) begin
          // strict compare keeps the lowest way on ties
          val_f   = 1'b1;
          best_ts = ts_i[w];
          val_w   = WAY_W'(w);
        end
      end
    end
  end

  always_comb begin
    if (hit_f)       res_o = pend_f ? RES_PEND : RES_HIT;
    else if (!free_f) res_o = RES_FAIL;
    else             res_o = RES_MISS;

    if (hit_f)      way_o = hit_w;
    else if (inv_f) way_o = inv_w;
    else if (val_f) way_o = val_w;
    else            way_o = '0;
  end
endmodule

// File: rtl/tag_arr_cnt.sv
module tag_arr_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tag_array_rsv.sv
module tag_array_rsv
  import tag_arr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int TS_W       = 24,
  parameter int CNT_W      = 16,
  parameter bit USE_FIFO   = 1'b0,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int TAG_W = BLK_W - SET_W,
  localparam int LINES = SETS * WAYS,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [BLK_W-1:0]  acc_blk_i,
  output logic [1:0]        res_o,
  output logic [IDX_W-1:0]  line_idx_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic              fill_dirty_i,
  input  logic              flush_i,
  output logic [CNT_W-1:0]  cnt_access_o,
  output logic [CNT_W-1:0]  cnt_miss_o,
  output logic [CNT_W-1:0]  cnt_pend_o,
  output logic [CNT_W-1:0]  cnt_fail_o
);
  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [TS_W-1:0]  lru_q [LINES];
  logic [TS_W-1:0]  alc_q [LINES];
  logic [TS_W-1:0]  now_q;

  logic [SET_W-1:0]            set_idx;
  logic [TAG_W-1:0]            key;
  logic [WAYS-1:0][1:0]        set_st;
  logic [WAYS-1:0][TAG_W-1:0]  set_tag;
  logic [WAYS-1:0][TS_W-1:0]   set_lru, set_alc, set_ts;
  logic [WAY_W-1:0]            way;
  logic                        do_alloc, do_touch, fill_blocked;

  assign set_idx = acc_blk_i[SET_W-1:0];
  assign key     = acc_blk_i[BLK_W-1:SET_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_st[w]  = st_q[{set_idx, WAY_W'(w)}];
      set_tag[w] = tag_q[{set_idx, WAY_W'(w)}];
      set_lru[w] = lru_q[{set_idx, WAY_W'(w)}];
      set_alc[w] = alc_q[{set_idx, WAY_W'(w)}];
    end
  end

  generate
    if (USE_FIFO) begin : g_fifo
      assign set_ts = set_alc;
    end else begin : g_lru
      assign set_ts = set_lru;
    end
  endgenerate

  tag_arr_lookup #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .TS_W (TS_W)
  ) u_lookup (
    .st_i (set_st),
    .tag_i(set_tag),
    .ts_i (set_ts),
    .key_i(key),
    .res_o(res_o),
    .way_o(way)
  );

  assign line_idx_o = {set_idx, way};
  assign wb_o       = (res_o == RES_MISS) && (set_st[way] == LS_MOD);
  assign wb_addr_o  = {set_tag[way], set_idx, {OFF_W{1'b0}}};

  assign do_alloc     = acc_valid_i && (res_o == RES_MISS);
  assign do_touch     = acc_valid_i && (res_o == RES_HIT || res_o == RES_PEND);
  assign fill_blocked = do_alloc && (fill_idx_i == line_idx_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LINES; l++) begin
        st_q[l]  <= LS_INV;
        tag_q[l] <= '0;
        lru_q[l] <= '0;
        alc_q[l] <= '0;
      end
    end else if (flush_i) begin
      for (int l = 0; l < LINES; l++) st_q[l] <= LS_INV;
    end else begin
      if (do_alloc) begin
        st_q[line_idx_o]  <= LS_RSV;
        tag_q[line_idx_o] <= key;
        lru_q[line_idx_o] <= now_q;
        alc_q[line_idx_o] <= now_q;
      end
      if (fill_valid_i && !fill_blocked)
        st_q[fill_idx_i] <= fill_dirty_i ? LS_MOD : LS_VAL;
      if (do_touch) lru_q[line_idx_o] <= now_q;
    end
  end

  logic [3:0]            cnt_inc;
  logic [3:0][CNT_W-1:0] cnt_val;

  assign cnt_inc = {acc_valid_i && res_o == RES_FAIL,
                    acc_valid_i && res_o == RES_PEND,
                    acc_valid_i && res_o == RES_MISS,
                    acc_valid_i};

  generate
    for (genvar k = 0; k < 4; k++) begin : g_cnt
      tag_arr_cnt #(.W(CNT_W)) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .inc_i (cnt_inc[k]),
        .cnt_o (cnt_val[k])
      );
    end
  endgenerate

  assign cnt_access_o = cnt_val[0];
  assign cnt_miss_o   = cnt_val[1];
  assign cnt_pend_o   = cnt_val[2];
  assign cnt_fail_o   = cnt_val[3];
endmodule

// File: rtl/tag_array_rsv_chk.sv
module tag_array_rsv_chk #(
  parameter int BLK_W = 28,
  parameter int IDX_W = 4,
  parameter int WAY_W = 2,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [BLK_W-1:0] acc_blk_i,
  input logic [1:0]       res_o,
  input logic [IDX_W-1:0] line_idx_o,
  input logic             wb_o,
  input logic             flush_i,
  input logic [CNT_W-1:0] cnt_access_o,
  input logic [CNT_W-1:0] cnt_miss_o,
  input logic [CNT_W-1:0] cnt_pend_o,
  input logic [CNT_W-1:0] cnt_fail_o
);
  a_r7_wb_only_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> res_o == 2'd2);

  a_r4_fail_points_way0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o == 2'd3 |-> line_idx_o[WAY_W-1:0] == '0);

  a_r9_flush_invalidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> res_o == 2'd2 && !wb_o);

  a_r5_alloc_reserves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && res_o == 2'd2 && !flush_i |=>
      (acc_blk_i != $past(acc_blk_i)) || res_o == 2'd1);

  a_r10_access_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> cnt_access_o == CNT_W'($past(cnt_access_o) + 1'b1));

  a_r10_access_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> $stable(cnt_access_o));

  a_r10_miss_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && res_o == 2'd2 |=> cnt_miss_o == CNT_W'($past(cnt_miss_o) + 1'b1));

  a_r10_pend_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && res_o == 2'd1 |=> cnt_pend_o == CNT_W'($past(cnt_pend_o) + 1'b1));

  a_r10_fail_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && res_o == 2'd3 |=> cnt_fail_o == CNT_W'($past(cnt_fail_o) + 1'b1));
endmodule

bind tag_array_rsv tag_array_rsv_chk #(
  .BLK_W(BLK_W),
  .IDX_W(IDX_W),
  .WAY_W(WAY_W),
  .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tag_array_rsv_tb.sv
module tag_array_rsv_tb;
  localparam int SETS  = 4;
  localparam int WAYS  = 4;
  localparam int LINES = 16;
  localparam int LB    = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5ns clk = ~clk;

  logic        av = 1'b0, fv = 1'b0, fd = 1'b0, fl = 1'b0;
  logic [27:0] blk = '0;
  logic [3:0]  fidx = '0;

  logic [1:0]  res_w   [2];
  logic [3:0]  idx_w   [2];
  logic        wb_w    [2];
  logic [31:0] wba_w   [2];
  logic [15:0] ca_w [2], cm_w [2], cp_w [2], cf_w [2];

  tag_array_rsv #(.USE_FIFO(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(av), .acc_blk_i(blk),
    .res_o(res_w[0]), .line_idx_o(idx_w[0]), .wb_o(wb_w[0]), .wb_addr_o(wba_w[0]),
    .fill_valid_i(fv), .fill_idx_i(fidx), .fill_dirty_i(fd), .flush_i(fl),
    .cnt_access_o(ca_w[0]), .cnt_miss_o(cm_w[0]), .cnt_pend_o(cp_w[0]), .cnt_fail_o(cf_w[0]));

  tag_array_rsv #(.USE_FIFO(1'b1)) u_dut_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(av), .acc_blk_i(blk),
    .res_o(res_w[1]), .line_idx_o(idx_w[1]), .wb_o(wb_w[1]), .wb_addr_o(wba_w[1]),
    .fill_valid_i(fv), .fill_idx_i(fidx), .fill_dirty_i(fd), .flush_i(fl),
    .cnt_access_o(ca_w[1]), .cnt_miss_o(cm_w[1]), .cnt_pend_o(cp_w[1]), .cnt_fail_o(cf_w[1]));

  int tnow;
  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) tnow <= 0;
    else         tnow <= tnow + 1;

  // model: state 0 inv, 1 reserved, 2 valid, 3 dirty
  int mst [2][LINES], mtag [2][LINES], mlru [2][LINES], malc [2][LINES];
  int mc  [2][4];
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void mlook(input int p, input int b, output int res,
                                output int idx, output int wb, output int wba);
    int s, tg, hw, vw, iw, best;
    bit hf, pf, ff, inf, vf;
    s = b % SETS; tg = b / SETS;
    hf = 0; pf = 0; ff = 0; inf = 0; vf = 0; hw = 0; vw = 0; iw = 0; best = 0;
    for (int w = 0; w < WAYS; w++) begin
      int l, ts;
      l  = s * WAYS + w;
      ts = (p == 1) ? malc[p][l] : mlru[p][l];
      if (!hf && mst[p][l] != 0 && mtag[p][l] == tg) begin
        hf = 1; hw = w; pf = (mst[p][l] == 1);
      end
      if (mst[p][l] != 1) begin
        ff = 1;
        if (mst[p][l] == 0) begin
          if (!inf) begin inf = 1; iw = w; end
        end else if (!vf || ts < best) begin
          vf = 1; best = ts; vw = w;
        end
      end
    end
    if (hf)       begin res = pf ? 1 : 0; idx = s * WAYS + hw; end
    else if (!ff) begin res = 3; idx = s * WAYS; end
    else          begin res = 2; idx = s * WAYS + (inf ? iw : vw); end
    wb  = (res == 2 && mst[p][idx] == 3) ? 1 : 0;
    wba = (mtag[p][idx] * SETS + s) * LB;
  endfunction

  task automatic step(input string tg, input bit a, input int b, input bit f,
                      input int fi, input bit d, input bit l);
    int er [2], ei [2], ew [2], ea [2];
    int t;
    @(negedge clk);
    av = a; blk = 28'(b); fv = f; fidx = 4'(fi); fd = d; fl = l;
    #1;
    t = tnow;
    for (int p = 0; p < 2; p++) begin
      mlook(p, b, er[p], ei[p], ew[p], ea[p]);
      chk(tg, int'(res_w[p]), er[p]);
      chk(tg, int'(idx_w[p]), ei[p]);
      chk({tg, " R7"}, int'(wb_w[p]), ew[p]);
      if (ew[p] != 0) chk("R7", int'(wba_w[p]), ea[p]);
      chk("R10 access", int'(ca_w[p]), mc[p][0]);
      chk("R10 miss", int'(cm_w[p]), mc[p][1]);
      chk("R10 pend", int'(cp_w[p]), mc[p][2]);
      chk("R10 fail", int'(cf_w[p]), mc[p][3]);
    end
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      if (a) begin
        mc[p][0]++;
        if (er[p] == 2) mc[p][1]++;
        if (er[p] == 1) mc[p][2]++;
        if (er[p] == 3) mc[p][3]++;
      end
      if (l) begin
        for (int k = 0; k < LINES; k++) mst[p][k] = 0;
      end else begin
        if (a && er[p] == 2) begin
          mst[p][ei[p]] = 1; mtag[p][ei[p]] = b / SETS;
          mlru[p][ei[p]] = t; malc[p][ei[p]] = t;
        end
        if (f && !(a && er[p] == 2 && ei[p] == fi)) mst[p][fi] = d ? 3 : 2;
        if (a && er[p] <= 1) mlru[p][ei[p]] = t;
      end
    end
  endtask

  // lookup without commit, literal expectations per instance
  task automatic peek(input string tg, input int b, input int r0, input int i0, input int w0,
                      input int r1, input int i1, input int w1);
    @(negedge clk);
    av = 0; blk = 28'(b); fv = 0; fl = 0;
    #1;
    chk(tg, int'(res_w[0]), r0); chk(tg, int'(idx_w[0]), i0); chk(tg, int'(wb_w[0]), w0);
    chk(tg, int'(res_w[1]), r1); chk(tg, int'(idx_w[1]), i1); chk(tg, int'(wb_w[1]), w1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < LINES; k++) begin
        mst[p][k] = 0; mtag[p][k] = 0; mlru[p][k] = 0; malc[p][k] = 0;
      end
      for (int k = 0; k < 4; k++) mc[p][k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state, R2 set 3 -> index 12
    peek("R1 R2", 7, 2, 12, 0, 2, 12, 0);
    step("R1", 0, 7, 0, 0, 0, 0);

    // R5 tie: fill invalid set-2 lines, all tag 0 with ts 0
    for (int w = 0; w < WAYS; w++) step("R8", 0, 0, 1, 8 + w, 0, 0);
    peek("R3 R8", 2, 0, 8, 0, 0, 8, 0);
    peek("R5 tie", 3 * SETS + 2, 2, 8, 0, 2, 8, 0);

    // set 1: reserve all four ways
    for (int t = 1; t <= 4; t++) step("R5", 1, t * SETS + 1, 0, 0, 0, 0);
    peek("R3 pend", 2 * SETS + 1, 1, 5, 0, 1, 5, 0);
    step("R4", 1, 5 * SETS + 1, 0, 0, 0, 0);
    peek("R4 fail", 5 * SETS + 1, 3, 4, 0, 3, 4, 0);
    // R11 fill way0 while pending-hitting it
    step("R11", 1, 1 * SETS + 1, 1, 4, 0, 0);
    peek("R11 after", 1 * SETS + 1, 0, 4, 0, 0, 4, 0);
    step("R8", 0, 0, 1, 5, 1, 0);
    step("R8", 0, 0, 1, 6, 0, 0);
    step("R8", 0, 0, 1, 7, 0, 0);
    step("R6", 1, 1 * SETS + 1, 0, 0, 0, 0);
    // R6: LRU evicts dirty way1 (addr 144); FIFO evicts way0
    peek("R6 R7", 6 * SETS + 1, 2, 5, 1, 2, 4, 0);
    chk("R7 addr", int'(wba_w[0]), (2 * SETS + 1) * LB);
    step("R5", 1, 6 * SETS + 1, 0, 0, 0, 0);

    // R9 flush with allocating access and a fill
    step("R9", 1, 9 * SETS + 3, 1, 2, 1, 1);
    peek("R9 flush", 9 * SETS + 3, 2, 12, 0, 2, 12, 0);
    peek("R9 flush", 1 * SETS + 1, 2, 4, 0, 2, 4, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int b, fi;
      bit a, f, d, l;
      b  = int'($urandom % 6) * SETS + int'($urandom % 4);
      a  = ($urandom % 4) != 0;
      f  = ($urandom % 3) == 0;
      fi = int'($urandom % 16);
      d  = $urandom % 2;
      l  = ($urandom % 80) == 0;
      step("R3 R5 R6 R11", a, b, f, fi, d, l);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule